// File: doc/BRIEF.md
# UART Transmitter with Clear-to-Send Gating

This block is the transmit half of a serial port. A producer hands bytes to a one-word holding register through a valid/ready write port. A frame shifter turns each byte into an asynchronous serial frame on `txd`. The frame is a start bit, 5 to 8 data bits, an optional parity bit and a stop bit, paced by a bit-rate enable pulse from an external rate generator.

Flow control decides when a held byte may move into the shifter. When automatic clear-to-send is enabled, a synchronised copy of the active-low `cts_n` pin gates each move. When it is disabled, the `cts_n` pin is ignored and a software pause bit gates each move instead. Neither gate ever stops a frame that has already started. A de-asserted `cts_n` or a set pause bit only holds back the next word, which waits in the holding register until the gate opens.

Back-pressure on the write port works like this. A byte is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low whenever the holding register is occupied. A producer may keep `wr_valid` high with any data while `wr_ready` is low; those bytes are neither taken nor do they disturb the held byte.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `tx_idle` is 1 and `wr_ready` is 1.
- R2: `wr_ready` is 1 exactly when the holding register is empty. A write offered while it is 0 is refused, and the held byte is still the one that gets transmitted.
- R3: A frame is a start bit of 0, then the data bits LSB first, then an optional parity bit, then one stop bit of 1. The data bit count is 5, 6, 7 or 8 for `word_len` 0, 1, 2 or 3. When `parity_en` is 1, the parity bit is the XOR of the data bits, inverted when `parity_odd` is 1. Each bit lasts OVERSAMPLE bit-rate enable pulses.
- R4: A frame that has started always runs to its stop bit, whatever `cts_n` and `sw_pause` do during it.
- R5: With `auto_cts_en`=1, no byte moves from the holding register to the shifter while the synchronised `cts_n` is 1. `cts_n` passes through SYNC_STAGES flops, so a fall of `cts_n` can release a held byte on the third rising edge after it at the earliest, with the default of two stages.
- R6: With `auto_cts_en`=0, bytes are sent whenever they are available, whatever level `cts_n` has.
- R7: With `auto_cts_en`=0, `sw_pause`=1 keeps a byte in the holding register and lets a frame already in flight finish. With `auto_cts_en`=1, `sw_pause` has no effect.
- R8: A byte written while the shifter is idle and the gate is open makes `hold_empty` 0 for one cycle. It then moves into the shifter, which sets `hold_empty` to 1 while `tx_idle` stays 0. `tx_idle` is 1 only when both the holding register and the shifter are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Bit-rate enable, OVERSAMPLE pulses per bit |
| wr_valid | input | 1 | Producer offers a byte |
| wr_ready | output | 1 | Holding register can take a byte |
| wr_data | input | DATA_W | Byte offered |
| word_len | input | 2 | Data bit count code: DATA_W-3 plus this value |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | Odd parity when 1, even parity when 0 |
| auto_cts_en | input | 1 | Gate transfers on the clear-to-send pin |
| sw_pause | input | 1 | Software hold of transfers when auto gating is off |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register is empty |
| tx_idle | output | 1 | Holding register and shifter are both empty |

## Verification
The bench builds the block with DATA_W=8, SYNC_STAGES=2 and OVERSAMPLE=4. The short bit time lets dozens of frames of every length and parity mode fit in a few thousand cycles. With the bit-rate enable randomly gapped, the bench's own frame decoder samples each bit at its middle tick, so a bit that runs long or short shows up as a wrong sampled value. Two stages make the synchroniser latency short enough to check cycle by cycle after a fall of `cts_n`. Directed sequences raise `cts_n` or set `sw_pause` while a frame is in flight, and they offer writes into a full holding register.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // Frame format as seen by the shifter at load time.
  typedef struct packed {
    logic       parity_en;
    logic       parity_odd;
    logic [1:0] wlen;
  } tx_fmt_t;

  // Data bits per frame: code 0 selects the shortest word, code 3 the full width.
  function automatic int wlen_bits(input logic [1:0] code, input int max_bits);
    return max_bits - 3 + int'(code);
  endfunction

endpackage

// File: rtl/uart_tx_cts_sync.sv
module uart_tx_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_async,
  output logic cts_ok
);

  logic [STAGES-1:0] chain_q;

  // Reset to the inactive level so nothing is released before a real sample.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= cts_n_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign cts_ok = ~chain_q[STAGES-1];

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              pop,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign wr_ready  = ~full_q;
  assign accept    = wr_valid & ~full_q;
  assign hold_data = data_q;
  assign hold_full = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= wr_data;
    end else if (pop) begin
      full_q <= 1'b0;
    end
  end

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !pop |=> full_q && $stable(data_q));

  // R2
  pop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> full_q);

endmodule

// File: rtl/uart_tx_frame_shift.sv
module uart_tx_frame_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  tx_fmt_t           fmt,
  output logic              busy,
  output logic              txd
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

  logic [FRAME_W-1:0] frame_vec, sreg_q;
  logic [LEN_W-1:0]   frame_len, left_q;
  logic [CNT_W-1:0]   tick_q;
  logic               busy_q;
  logic               bit_end;
  int                 nb;
  logic               par;

  // Build the whole frame once, at load time, from the current format.
  always_comb begin
    nb        = wlen_bits(fmt.wlen, DATA_W);
    par       = fmt.parity_odd;
    frame_vec = '1;
    frame_vec[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nb) begin
        frame_vec[i+1] = load_data[i];
        par            = par ^ load_data[i];
      end
    end
    for (int j = 1; j < FRAME_W; j++) begin
      if (fmt.parity_en && (j == nb + 1)) frame_vec[j] = par;
    end
    frame_len = LEN_W'(nb + 2 + (fmt.parity_en ? 1 : 0));
  end

  assign bit_end = busy_q & tick_en & (tick_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sreg_q <= '1;
      left_q <= '0;
      tick_q <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      sreg_q <= frame_vec;
      left_q <= frame_len;
      tick_q <= '0;
    end else if (busy_q && tick_en) begin
      if (tick_q == CNT_LAST) begin
        tick_q <= '0;
        if (left_q == LEN_ONE) begin
          busy_q <= 1'b0;
        end else begin
          sreg_q <= {1'b1, sreg_q[FRAME_W-1:1]};
          left_q <= left_q - LEN_ONE;
        end
      end else begin
        tick_q <= tick_q + CNT_W'(1);
      end
    end
  end

  assign busy = busy_q;
  assign txd  = busy_q ? sreg_q[0] : 1'b1;

  // R4
  frame_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !(bit_end && left_q == LEN_ONE) |=> busy_q);

  // R3
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q && !txd);

  // R8
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q >= LEN_ONE) && (left_q <= LEN_W'(FRAME_W)));

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        word_len,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              auto_cts_en,
  input  logic              sw_pause,
  input  logic              cts_n,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_idle
);

  logic              cts_ok;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              shift_busy;
  logic              gate_open;
  logic              load;
  tx_fmt_t           fmt;

  uart_tx_cts_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cts_n_async (cts_n),
    .cts_ok      (cts_ok)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) hold_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_ready  (wr_ready),
    .pop       (load),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  // Auto gating follows the pin; otherwise only the software pause counts.
  assign gate_open = auto_cts_en ? cts_ok : ~sw_pause;
  assign load      = hold_full & ~shift_busy & gate_open;

  assign fmt.parity_en  = parity_en;
  assign fmt.parity_odd = parity_odd;
  assign fmt.wlen       = word_len;

  uart_tx_frame_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .load      (load),
    .load_data (hold_data),
    .fmt       (fmt),
    .busy      (shift_busy),
    .txd       (txd)
  );

  assign hold_empty = ~hold_full;
  assign tx_idle    = ~hold_full & ~shift_busy;

  // R5
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_cts_en && !cts_ok && hold_full |=> hold_full);

  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en && sw_pause && hold_full |=> hold_full);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && shift_busy |=> hold_full);

endmodule

// File: tb/uart_tx_flow_tb_top.sv
`timescale 1ns/1ps
module uart_tx_flow_tb_top;

  localparam int DW  = 8;
  localparam int OVS = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    word_len = 2'd3;
  logic          parity_en = 1'b0;
  logic          parity_odd = 1'b0;
  logic          auto_cts_en = 1'b0;
  logic          sw_pause = 1'b0;
  logic          cts_n = 1'b1;
  logic          txd, hold_empty, tx_idle;

  uart_tx_flow #(.DATA_W(DW), .OVERSAMPLE(OVS), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .word_len(word_len), .parity_en(parity_en), .parity_odd(parity_odd),
    .auto_cts_en(auto_cts_en), .sw_pause(sw_pause), .cts_n(cts_n),
    .txd(txd), .hold_empty(hold_empty), .tx_idle(tx_idle)
  );

  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  int writes_done = 0;
  int cycle = 0;
  logic [15:0] exp_bits_q[$];
  int          exp_len_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected frame bits, bit 0 first on the line.
  function automatic void build_frame(input logic [7:0] d, input logic [1:0] wl,
                                      input bit pe, input bit po,
                                      output logic [15:0] v, output int len);
    int nb;
    int idx;
    bit p;
    nb = 5 + int'(wl);
    v = '1;
    v[0] = 1'b0;
    p = po;
    for (int i = 0; i < nb; i++) begin
      v[1+i] = d[i];
      p = p ^ d[i];
    end
    idx = 1 + nb;
    if (pe) begin
      v[idx] = p;
      idx++;
    end
    v[idx] = 1'b1;
    len = idx + 1;
  endfunction

  // Serial decoder, bit-rate enable source and watchdog.
  bit          mon_busy = 0;
  int          consumed = 0;
  int          bitk = 0;
  int          cur_len = 0;
  logic [15:0] cur_exp = '1;
  logic [15:0] got = '0;

  always @(negedge clk) begin
    cycle++;
    if (cycle > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (tick_en && mon_busy) consumed++;
    if (!rst_n) begin
      mon_busy = 0;
    end else if (!mon_busy) begin
      if (txd == 1'b0) begin
        mon_busy = 1;
        consumed = 0;
        bitk = 0;
        got = '1;
        if (exp_bits_q.size() == 0) begin
          check(0, "R3", "unexpected start bit", 1, 0);
          cur_exp = '1;
          cur_len = 11;
        end else begin
          cur_exp = exp_bits_q.pop_front();
          cur_len = exp_len_q.pop_front();
        end
      end
    end else if (consumed >= bitk * OVS + OVS / 2) begin
      got[bitk] = txd;
      bitk++;
      if (bitk == cur_len) begin
        int mism;
        mism = 0;
        for (int i = 0; i < cur_len; i++) if (got[i] !== cur_exp[i]) mism++;
        check(mism == 0, "R3", "frame bits", int'(got), int'(cur_exp));
        frames_seen++;
        mon_busy = 0;
      end
    end
    tick_en = rst_n && (($urandom % 3) != 0);
  end

  task automatic do_write(input logic [7:0] d);
    logic [15:0] v;
    int len;
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data = d;
    build_frame(d, word_len, parity_en, parity_odd, v, len);
    exp_bits_q.push_back(v);
    exp_len_q.push_back(len);
    writes_done++;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(tx_idle && !mon_busy)) @(negedge clk);
  endtask

  int base;

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1", "txd idle", txd, 1);
    check(hold_empty == 1'b1, "R1", "hold_empty", hold_empty, 1);
    check(tx_idle == 1'b1, "R1", "tx_idle", tx_idle, 1);
    check(wr_ready == 1'b1, "R1", "wr_ready", wr_ready, 1);

    // R8 flag timing on a write into an idle, open transmitter
    base = frames_seen;
    do_write(8'hA5);
    check(hold_empty == 1'b0, "R8", "hold_empty after write", hold_empty, 0);
    check(tx_idle == 1'b0, "R8", "tx_idle after write", tx_idle, 0);
    @(negedge clk);
    check(hold_empty == 1'b1, "R8", "hold_empty after move", hold_empty, 1);
    check(tx_idle == 1'b0, "R8", "tx_idle while shifting", tx_idle, 0);
    wait_idle();
    check(frames_seen == base + 1, "R8", "frames", frames_seen, base + 1);

    // R2 refused writes while full; R7 pause holds the byte
    sw_pause = 1'b1;
    base = frames_seen;
    do_write(8'h3C);
    wr_valid = 1'b1;
    wr_data = 8'hC3;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(wr_ready == 1'b0, "R2", "wr_ready while full", wr_ready, 0);
    end
    wr_valid = 1'b0;
    repeat (150) @(negedge clk);
    check(hold_empty == 1'b0, "R7", "held during pause", hold_empty, 0);
    check(frames_seen == base, "R7", "no frame during pause", frames_seen, base);
    sw_pause = 1'b0;
    wait_idle();
    check(frames_seen == base + 1, "R2", "held byte sent once", frames_seen, base + 1);

    // R7 pause set during a frame: that frame finishes, next one waits
    base = frames_seen;
    do_write(8'h5A);
    while (!mon_busy) @(negedge clk);
    sw_pause = 1'b1;
    do_write(8'h81);
    while (mon_busy) @(negedge clk);
    repeat (150) @(negedge clk);
    check(frames_seen == base + 1, "R7", "in-flight frame done", frames_seen, base + 1);
    check(hold_empty == 1'b0, "R7", "next byte held", hold_empty, 0);
    sw_pause = 1'b0;
    wait_idle();
    check(frames_seen == base + 2, "R7", "resume after pause", frames_seen, base + 2);

    // R6 auto gating off: inactive cts_n is ignored
    cts_n = 1'b1;
    base = frames_seen;
    do_write(8'h0F);
    wait_idle();
    check(frames_seen == base + 1, "R6", "sent with cts_n high", frames_seen, base + 1);

    // R4 / R5 auto gating: de-assert during a frame
    auto_cts_en = 1'b1;
    cts_n = 1'b0;
    repeat (4) @(negedge clk);
    base = frames_seen;
    do_write(8'hE7);
    while (!mon_busy) @(negedge clk);
    cts_n = 1'b1;
    sw_pause = 1'b1;
    do_write(8'h42);
    while (mon_busy) @(negedge clk);
    repeat (150) @(negedge clk);
    check(frames_seen == base + 1, "R4", "started frame completes", frames_seen, base + 1);
    check(hold_empty == 1'b0, "R5", "byte held while cts_n high", hold_empty, 0);
    cts_n = 1'b0;
    @(negedge clk);
    check(hold_empty == 1'b0, "R5", "held one edge after fall", hold_empty, 0);
    @(negedge clk);
    check(hold_empty == 1'b0, "R5", "held two edges after fall", hold_empty, 0);
    @(negedge clk);
    check(hold_empty == 1'b1, "R5", "released third edge", hold_empty, 1);
    wait_idle();
    check(frames_seen == base + 2, "R7", "pause ignored with auto on", frames_seen, base + 2);
    sw_pause = 1'b0;
    auto_cts_en = 1'b0;

    // R3 directed corners: all-zero and all-one data in every parity mode
    for (int m = 0; m < 4; m++) begin
      word_len = 2'(m);
      parity_en = (m != 0);
      parity_odd = m[0];
      do_write(8'h00);
      do_write(8'hFF);
      wait_idle();
    end

    // R3 random formats and data, one to three bytes back to back
    for (int it = 0; it < 30; it++) begin
      int nw;
      word_len = 2'($urandom % 4);
      parity_en = 1'($urandom % 2);
      parity_odd = 1'($urandom % 2);
      nw = 1 + int'($urandom % 3);
      for (int w = 0; w < nw; w++) do_write(8'($urandom));
      wait_idle();
    end

    check(exp_bits_q.size() == 0, "R3", "frames left unsent", exp_bits_q.size(), 0);
    check(frames_seen == writes_done, "R3", "frame count", frames_seen, writes_done);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule